// File: doc/BRIEF.md
# Register Patch Table Engine

This block applies a list of register patches stored in a table memory. After a start pulse it reads the table one word at a time from a base address. It treats each group of three words as one patch. For each patch it reads the target register over a memory-mapped bus, clears the bits named by one mask, sets the bits named by another, and writes the result back. The walk ends at the first patch whose three words are all zero. It also ends early if any single bus or table transfer waits too long for its ready response.

Both ports are simple request/ready masters. A request stays high, with its address and data steady, until ready is seen high at a rising clock edge. Only one request is active at any time. The engine drives busy while it works and pulses done for one cycle when the walk ends. If the walk ended because of a stall, a sticky timeout flag is raised.

Top module: `regpatch_engine`

## Requirements
- R1: A patch at index k occupies table words base+3k, base+3k+1 and base+3k+2. These hold, in that order, the target register address, the set mask and the clear mask. Table words are read in strictly ascending order starting at the base address sampled at start, so a walk over n patches reads exactly 3(n+1) words.
- R2: The walk ends at the first patch whose three words are all zero, without any register access for that patch. A patch with at least one nonzero word is applied, including one that targets address 0 or one with both masks zero.
- R3: The value written to the target register equals (value read AND NOT clear mask) OR set mask, so a bit named in both masks ends up set.
- R4: For each applied patch there is exactly one register read followed directly by exactly one register write to the same address. The next table read starts only after that write completes. Patches are applied in table order.
- R5: Each request (table read, register read or register write) and its address and write data stay unchanged until ready is sampled high at a rising edge. At most one of the three requests is high in any cycle.
- R6: If a request sees no ready within TIMEOUT_CYC cycles (default 256), it stays high for exactly TIMEOUT_CYC cycles and then drops. Done then pulses with timeout high, and no further access is made. Timeout stays high until the next accepted start clears it.
- R7: Start is accepted only while busy is low. Busy is high from the cycle after an accepted start through the done cycle. A start pulse while busy has no effect on the run.
- R8: Done is high for exactly one cycle per run.
- R9: After reset busy, done, timeout and all three requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a table walk (used while idle only) |
| tbl_base | input | TAW | Word address of the first patch |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| timeout | output | 1 | Last walk ended on a stalled transfer |
| tbl_rd | output | 1 | Table read request |
| tbl_addr | output | TAW | Table word address |
| tbl_rdata | input | DW | Table read data, valid with tbl_ack |
| tbl_ack | input | 1 | Table read ready |
| bus_rd | output | 1 | Register read request |
| bus_wr | output | 1 | Register write request |
| bus_addr | output | AW | Register address |
| bus_wdata | output | DW | Register write data |
| bus_rdata | input | DW | Register read data, valid with bus_ready |
| bus_ready | input | 1 | Register transfer ready |

## Verification
A directed table mixes overlapping masks, a patch at address 0 and a patch with empty masks. This separates set-over-clear priority from clear-over-set, and a zero-address stop from an all-zero stop. An empty table and stalls on each port test the end conditions, the exact stall length and the sticky flag. A start pulse given mid-walk shows whether the engine restarts.

Seeded random tables reuse addresses, so a wrong order of application shows up in the final register values. Their random masks and random ready latencies of zero to three cycles expose any stale capture of read data or table words.

// File: rtl/regpatch_pkg.sv
package regpatch_pkg;

   localparam int ENTRY_WORDS = 3;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FETCH = 3'd1,
      ST_RDREG = 3'd2,
      ST_WRREG = 3'd3,
      ST_FIN   = 3'd4
   } walk_state_e;

   typedef enum logic [1:0] {
      W_ADDR = 2'd0,
      W_SET  = 2'd1,
      W_CLR  = 2'd2
   } word_slot_e;

endpackage

// File: rtl/regpatch_merge.sv
module regpatch_merge #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] rd_val,
   input  logic [DW-1:0] set_mask,
   input  logic [DW-1:0] clr_mask,
   output logic [DW-1:0] wr_val
);

   for (genvar b = 0; b < DW; b++) begin : g_bit
      // set wins over clear on the same bit
      assign wr_val[b] = set_mask[b] | (rd_val[b] & ~clr_mask[b]);
   end

endmodule

// File: rtl/regpatch_watchdog.sv
module regpatch_watchdog #(
   parameter int LIMIT = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pending,
   input  logic hshake,
   output logic expired
);

   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

   logic [CW-1:0] wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wait_q <= '0;
      else if (!pending || hshake)
         wait_q <= '0;
      else if (!expired)
         wait_q <= wait_q + 1'b1;
      else
         wait_q <= '0;
   end

   assign expired = pending && !hshake && (wait_q == CW'(LIMIT - 1));

endmodule

// File: rtl/regpatch_fetch.sv
module regpatch_fetch
   import regpatch_pkg::*;
#(
   parameter int DW  = 32,
   parameter int TAW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [TAW-1:0] base,
   input  logic           hshake,
   input  logic [DW-1:0]  rdata,
   output logic [TAW-1:0] word_addr,
   output logic           last_word,
   output logic           all_zero,
   output logic [DW-1:0]  ent_addr,
   output logic [DW-1:0]  ent_set,
   output logic [DW-1:0]  ent_clr
);

   logic [TAW-1:0] ptr_q;
   logic [1:0]     slot_q;
   logic [DW-1:0]  word_q [ENTRY_WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         slot_q <= 2'(W_ADDR);
      end else if (load) begin
         ptr_q  <= base;
         slot_q <= 2'(W_ADDR);
      end else if (hshake) begin
         ptr_q  <= ptr_q + 1'b1;
         slot_q <= last_word ? 2'(W_ADDR) : slot_q + 1'b1;
      end
   end

   for (genvar g = 0; g < ENTRY_WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q[g] <= '0;
         else if (hshake && (slot_q == 2'(g)))
            word_q[g] <= rdata;
      end
   end

   assign word_addr = ptr_q;
   assign last_word = (slot_q == 2'(ENTRY_WORDS - 1));
   // judged while the final word is on the data input
   assign all_zero  = (word_q[W_ADDR] == '0) && (word_q[W_SET] == '0) && (rdata == '0);
   assign ent_addr  = word_q[W_ADDR];
   assign ent_set   = word_q[W_SET];
   assign ent_clr   = word_q[W_CLR];

endmodule

// File: rtl/regpatch_engine.sv
module regpatch_engine
   import regpatch_pkg::*;
#(
   parameter int DW          = 32,
   parameter int AW          = 32,
   parameter int TAW         = 16,
   parameter int TIMEOUT_CYC = 256
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [TAW-1:0] tbl_base,
   output logic           busy,
   output logic           done,
   output logic           timeout,
   output logic           tbl_rd,
   output logic [TAW-1:0] tbl_addr,
   input  logic [DW-1:0]  tbl_rdata,
   input  logic           tbl_ack,
   output logic           bus_rd,
   output logic           bus_wr,
   output logic [AW-1:0]  bus_addr,
   output logic [DW-1:0]  bus_wdata,
   input  logic [DW-1:0]  bus_rdata,
   input  logic           bus_ready
);

   if (AW > DW) begin : g_bad_aw
      $error("regpatch_engine: AW must not exceed DW");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_to
      $error("regpatch_engine: TIMEOUT_CYC must be at least 2");
   end
   if (TAW < 2) begin : g_bad_taw
      $error("regpatch_engine: TAW must be at least 2");
   end

   walk_state_e   state_q;
   logic          timeout_q;
   logic [DW-1:0] rd_q;

   logic          load;
   logic          tbl_hs;
   logic          bus_hs;
   logic          wd_expired;
   logic          last_word;
   logic          all_zero;
   logic [DW-1:0] ent_addr_w;
   logic [DW-1:0] ent_set_w;
   logic [DW-1:0] ent_clr_w;
   logic [DW-1:0] merged_w;

   assign load   = (state_q == ST_IDLE) && start;
   assign tbl_hs = tbl_rd && tbl_ack;
   assign bus_hs = (bus_rd || bus_wr) && bus_ready;

   regpatch_fetch #(.DW(DW), .TAW(TAW)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .base      (tbl_base),
      .hshake    (tbl_hs),
      .rdata     (tbl_rdata),
      .word_addr (tbl_addr),
      .last_word (last_word),
      .all_zero  (all_zero),
      .ent_addr  (ent_addr_w),
      .ent_set   (ent_set_w),
      .ent_clr   (ent_clr_w)
   );

   regpatch_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wd (
      .clk     (clk),
      .rst_n   (rst_n),
      .pending (tbl_rd || bus_rd || bus_wr),
      .hshake  (tbl_hs || bus_hs),
      .expired (wd_expired)
   );

   regpatch_merge #(.DW(DW)) u_merge (
      .rd_val   (rd_q),
      .set_mask (ent_set_w),
      .clr_mask (ent_clr_w),
      .wr_val   (merged_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         timeout_q <= 1'b0;
         rd_q      <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q   <= ST_FETCH;
                  timeout_q <= 1'b0;
               end
            end
            ST_FETCH: begin
               if (tbl_ack) begin
                  if (last_word)
                     state_q <= all_zero ? ST_FIN : ST_RDREG;
               end else if (wd_expired) begin
                  state_q   <= ST_FIN;
                  timeout_q <= 1'b1;
               end
            end
            ST_RDREG: begin
               if (bus_ready) begin
                  rd_q    <= bus_rdata;
                  state_q <= ST_WRREG;
               end else if (wd_expired) begin
                  state_q   <= ST_FIN;
                  timeout_q <= 1'b1;
               end
            end
            ST_WRREG: begin
               if (bus_ready) begin
                  state_q <= ST_FETCH;
               end else if (wd_expired) begin
                  state_q   <= ST_FIN;
                  timeout_q <= 1'b1;
               end
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_FIN);
   assign timeout   = timeout_q;
   assign tbl_rd    = (state_q == ST_FETCH);
   assign bus_rd    = (state_q == ST_RDREG);
   assign bus_wr    = (state_q == ST_WRREG);
   assign bus_addr  = ent_addr_w[AW-1:0];
   assign bus_wdata = merged_w;

endmodule

// File: rtl/regpatch_checker.sv
module regpatch_checker #(
   parameter int DW  = 32,
   parameter int AW  = 32,
   parameter int TAW = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           busy,
   input logic           done,
   input logic           timeout,
   input logic           tbl_rd,
   input logic [TAW-1:0] tbl_addr,
   input logic           tbl_ack,
   input logic           bus_rd,
   input logic           bus_wr,
   input logic [AW-1:0]  bus_addr,
   input logic [DW-1:0]  bus_wdata,
   input logic           bus_ready,
   input logic [DW-1:0]  ent_set,
   input logic [DW-1:0]  ent_clr
);

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                       // R8

   AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({tbl_rd, bus_rd, bus_wr}) <= 1);                            // R5

   AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) && !bus_ready |=>
         done || ((bus_rd || bus_wr) && $stable(bus_addr) && $stable(bus_wr))); // R5

   AST_TBL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_rd && !tbl_ack |=> done || (tbl_rd && $stable(tbl_addr)));         // R5

   AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_wr) |-> $past(bus_rd && bus_ready));                         // R4

   AST_FETCH_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_ready |=> tbl_rd);                                       // R4

   AST_WDATA_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> ((bus_wdata & ent_set) == ent_set) &&
                 ((bus_wdata & ent_clr & ~ent_set) == '0));                  // R3

   AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout) |-> done);                                              // R6

   AST_TIMEOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      timeout && !(start && !busy) |=> timeout);                             // R6

   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(tbl_rd || bus_rd || bus_wr));                              // R7

   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start |=> busy && !timeout);                                  // R7

endmodule

bind regpatch_engine regpatch_checker #(.DW(DW), .AW(AW), .TAW(TAW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .timeout   (timeout),
   .tbl_rd    (tbl_rd),
   .tbl_addr  (tbl_addr),
   .tbl_ack   (tbl_ack),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_ready (bus_ready),
   .ent_set   (ent_set_w),
   .ent_clr   (ent_clr_w)
);

// File: tb/tb_regpatch_engine.sv
module tb_regpatch_engine;

   localparam int DW  = 32;
   localparam int AW  = 32;
   localparam int TAW = 16;
   localparam int TO  = 256;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [TAW-1:0] tbl_base = '0;
   logic           busy, done, timeout, tbl_rd, bus_rd, bus_wr;
   logic [TAW-1:0] tbl_addr;
   logic [AW-1:0]  bus_addr;
   logic [DW-1:0]  bus_wdata;
   logic [DW-1:0]  tbl_rdata = '0;
   logic           tbl_ack = 1'b0;
   logic [DW-1:0]  bus_rdata = '0;
   logic           bus_ready = 1'b0;

   regpatch_engine #(.DW(DW), .AW(AW), .TAW(TAW), .TIMEOUT_CYC(TO)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .tbl_base(tbl_base),
      .busy(busy), .done(done), .timeout(timeout),
      .tbl_rd(tbl_rd), .tbl_addr(tbl_addr), .tbl_rdata(tbl_rdata), .tbl_ack(tbl_ack),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready)
   );

   always #4 clk = ~clk;

   logic [31:0] tmem [0:127];
   logic [31:0] rmem [0:63];
   logic [31:0] xmem [0:63];
   int tlat = 0, blat = 0, tcnt = 0, bcnt = 0;
   bit hang_tbl = 0, hang_bus = 0;
   int done_n = 0, wr_n = 0, rd_n = 0, tn = 0, rdrun = 0, rdrun_max = 0;
   int tfirst = 0;
   int wr_log [0:63];
   int n_cmp = 0, n_bad = 0;

   logic [31:0] ea [0:7];
   logic [31:0] es [0:7];
   logic [31:0] ec [0:7];

   function automatic logic [31:0] f_patch(logic [31:0] v, logic [31:0] s, logic [31:0] c);
      return (v & ~c) | s;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   // bus and table responders plus monitors, all on the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (done) done_n++;
         if (bus_rd) rdrun++; else rdrun = 0;
         if (rdrun > rdrun_max) rdrun_max = rdrun;
         if (tbl_ack) begin
            tbl_ack = 1'b0; tcnt = 0;
         end else if (tbl_rd && !hang_tbl) begin
            if (tcnt >= tlat) begin
               tbl_ack = 1'b1;
               tbl_rdata = tmem[tbl_addr[6:0]];
               if (tn == 0) tfirst = int'(tbl_addr);
               tn++;
            end else tcnt++;
         end else tcnt = 0;
         if (bus_ready) begin
            bus_ready = 1'b0; bcnt = 0;
         end else if ((bus_rd || bus_wr) && !hang_bus) begin
            if (bcnt >= blat) begin
               bus_ready = 1'b1;
               if (bus_rd) begin
                  bus_rdata = rmem[bus_addr[5:0]];
                  rd_n++;
               end else begin
                  rmem[bus_addr[5:0]] = bus_wdata;
                  wr_log[wr_n] = int'(bus_addr[5:0]);
                  wr_n++;
               end
            end else bcnt++;
         end else bcnt = 0;
      end
   end

   task automatic load_table(input int base, input int n);
      for (int k = 0; k < n; k++) begin
         tmem[base + 3*k]     = ea[k];
         tmem[base + 3*k + 1] = es[k];
         tmem[base + 3*k + 2] = ec[k];
      end
      tmem[base + 3*n]     = '0;
      tmem[base + 3*n + 1] = '0;
      tmem[base + 3*n + 2] = '0;
   endtask

   task automatic launch(input int base);
      @(negedge clk);
      done_n = 0; wr_n = 0; rd_n = 0; tn = 0; rdrun_max = 0;
      tbl_base = TAW'(base);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R7", "busy after start", 32'(busy), 1);
   endtask

   task automatic wait_done(input string req);
      int k = 0;
      while (!done && k < 3000) begin
         @(negedge clk);
         k++;
      end
      chk(done == 1'b1, req, "done reached", 32'(done), 1);
      chk(busy == 1'b1, "R7", "busy during done", 32'(busy), 1);
      repeat (3) @(negedge clk);
   endtask

   task automatic expect_regs(input int base, input int n, input string tag);
      int bad = 0;
      for (int k = 0; k < n; k++)
         xmem[ea[k][5:0]] = f_patch(xmem[ea[k][5:0]], es[k], ec[k]);
      for (int i = 0; i < 64; i++)
         if (rmem[i] !== xmem[i]) bad++;
      chk(bad == 0, "R3", {tag, " register image"}, 32'(bad), 0);
      chk(wr_n == n, "R4", {tag, " write count"}, 32'(wr_n), 32'(n));
      chk(rd_n == n, "R4", {tag, " read count"}, 32'(rd_n), 32'(n));
      chk(tn == 3*(n+1), "R1", {tag, " table words"}, 32'(tn), 32'(3*(n+1)));
      chk(tfirst == base, "R1", {tag, " first word"}, 32'(tfirst), 32'(base));
      chk(done_n == 1, "R8", {tag, " done cycles"}, 32'(done_n), 1);
      chk(timeout == 1'b0, "R6", {tag, " no timeout"}, 32'(timeout), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL R6 watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      for (int i = 0; i < 128; i++) tmem[i] = '0;
      for (int i = 0; i < 64; i++) begin rmem[i] = '0; xmem[i] = '0; end
      repeat (3) @(negedge clk);
      // R9 reset state
      chk({busy, done, timeout, tbl_rd, bus_rd, bus_wr} == 6'b0, "R9", "reset outputs",
          32'({busy, done, timeout, tbl_rd, bus_rd, bus_wr}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // directed: overlapping masks, address 0 target, empty masks
      rmem[5] = 32'h1234_5678; rmem[0] = 32'hDEAD_BEEF; rmem[9] = 32'hCAFE_F00D;
      for (int i = 0; i < 64; i++) xmem[i] = rmem[i];
      ea[0] = 32'd5; es[0] = 32'h0000_FF00; ec[0] = 32'h00FF_FF00;
      ea[1] = 32'd0; es[1] = 32'h0;         ec[1] = 32'hFFFF_FFFF;
      ea[2] = 32'd9; es[2] = 32'h0;         ec[2] = 32'h0;
      load_table(10, 3);
      tlat = 1; blat = 2;
      launch(10);
      wait_done("R2");
      chk(rmem[5] == 32'h1200_FF78, "R3", "set beats clear", rmem[5], 32'h1200_FF78);
      chk(rmem[0] == 32'h0, "R2", "address 0 patch applied", rmem[0], 0);
      chk(rmem[9] == 32'hCAFE_F00D, "R2", "empty masks rewrite", rmem[9], 32'hCAFE_F00D);
      chk(wr_log[0] == 5 && wr_log[1] == 0 && wr_log[2] == 9, "R4", "write order",
          32'(wr_log[1]), 0);
      expect_regs(10, 3, "directed");

      // empty table
      load_table(40, 0);
      tlat = 0; blat = 0;
      launch(40);
      wait_done("R2");
      chk(rd_n == 0 && wr_n == 0, "R2", "empty table no access", 32'(rd_n + wr_n), 0);
      chk(tn == 3, "R1", "empty table words", 32'(tn), 3);
      chk(done_n == 1, "R8", "empty table done cycles", 32'(done_n), 1);

      // start while busy is ignored
      for (int k = 0; k < 4; k++) begin
         ea[k] = 32'(k + 20); es[k] = 32'h1 << k; ec[k] = 32'hF0;
      end
      for (int i = 0; i < 64; i++) xmem[i] = rmem[i];
      load_table(60, 4);
      tlat = 3; blat = 3;
      launch(60);
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done("R7");
      repeat (20) @(negedge clk);
      chk(busy == 1'b0, "R7", "idle after run", 32'(busy), 0);
      expect_regs(60, 4, "restart-ignored");

      // register bus stall
      ea[0] = 32'd3; es[0] = 32'hFF; ec[0] = 32'h0;
      load_table(0, 1);
      tlat = 0; blat = 0; hang_bus = 1;
      launch(0);
      wait_done("R6");
      chk(timeout == 1'b1, "R6", "timeout flag", 32'(timeout), 1);
      chk(rdrun_max == TO, "R6", "stall request length", 32'(rdrun_max), TO);
      chk(wr_n == 0, "R6", "no write after stall", 32'(wr_n), 0);
      chk(!bus_rd && !busy, "R6", "stopped after stall", 32'({bus_rd, busy}), 0);
      repeat (10) @(negedge clk);
      chk(timeout == 1'b1, "R6", "flag held", 32'(timeout), 1);
      hang_bus = 0;

      // next start clears flag
      for (int i = 0; i < 64; i++) xmem[i] = rmem[i];
      launch(0);
      chk(timeout == 1'b0, "R6", "flag cleared by start", 32'(timeout), 0);
      wait_done("R6");
      expect_regs(0, 1, "after-stall");

      // table stall
      hang_tbl = 1;
      launch(0);
      wait_done("R6");
      chk(timeout == 1'b1 && rd_n == 0, "R6", "table stall", 32'({timeout, 31'(rd_n)}), 32'h8000_0000);
      hang_tbl = 0;

      // seeded random tables
      for (int r = 0; r < 24; r++) begin
         int n = 1 + int'($urandom % 7);
         int base = int'($urandom % 90);
         for (int i = 0; i < 64; i++) begin rmem[i] = $urandom; xmem[i] = rmem[i]; end
         for (int k = 0; k < n; k++) begin
            ea[k] = 32'($urandom % 16);
            es[k] = $urandom & $urandom;
            ec[k] = $urandom;
            if (ea[k] == 0 && es[k] == 0 && ec[k] == 0) es[k] = 32'h1;
         end
         load_table(base, n);
         tlat = int'($urandom % 4); blat = int'($urandom % 4);
         launch(base);
         wait_done("R2");
         expect_regs(base, n, "random");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule